// File: doc/BRIEF.md
# Bank-switched two-port synchronous memory

The block is a synchronous memory with two independent access ports. Its storage is split into equal banks, and each bank has only one access path. In any clock cycle each port picks a bank and a word inside it. The two ports can therefore work at the same time only when they are in different banks.

If both ports address the same bank in one cycle, there is no arbitration. Neither access takes effect, and each port raises a collision flag. Writes use a mask of 9-bit lanes. Each port can present read data in one of two ways: straight from the capture register, or from an extra output register. An asynchronous output enable controls only whether the data bus is driven.

The default geometry is kept small for elaboration: 8 banks of 64 words. The full part uses `BANK_AW = 6` and `WORD_AW = 10`, which gives 64 banks of 1K words of 36 bits.

Top module: `bsw_dual_bank_ram`

## Requirements
- R1: Storage is 2^BANK_AW banks of 2^WORD_AW words of NBYTES*BYTE_W (36) bits. A word is addressed by the pair (bank, word). The same word address in two different banks names two separate words.
- R2: The chip-select pair, write flag, lane mask, bank, word address and write data are captured on the rising clock edge. A read captured on edge k in flow-through mode (`*_pipe`=0) shows its data on `*_dout` after edge k+1.
- R3: In pipelined mode (`*_pipe`=1) the same read shows its data after edge k+2. After edge k+1 the output still shows the previous flow-through value.
- R4: Lane mask bit i (active high) lets a write change bits [9i+8:9i]. Lanes whose mask bit is 0 keep their old contents.
- R5: A port is selected only when `*_cs_n`=0 and `*_cs`=1. A deselected port writes nothing, and its read output holds its last value.
- R6: When both ports are selected with the same bank in the same capture cycle, neither write changes memory, and each reading port captures all zeros.
- R7: Each port's `*_coll` goes high for one cycle for each colliding request. It follows that port's read latency: after edge k+1 in flow-through mode, after edge k+2 in pipelined mode.
- R8: Selected ports in different banks work fully in the same cycle, including a write on one port and a read on the other.
- R9: With `*_oe`=0, `*_dout` is 0 and `*_dout_en` is 0 at once, with no clock. The read pipeline keeps its state, and raising `*_oe` shows it again.
- R10: While reset is active and after it ends, every `*_dout` (with `*_oe`=1) and every `*_coll` is 0.
- R11: A read that follows a write on the same port returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pa_cs_n | input | 1 | Port A select, active low |
| pa_cs | input | 1 | Port A select, active high |
| pa_we | input | 1 | Port A: 1 write, 0 read |
| pa_be | input | NBYTES | Port A write lane mask |
| pa_bank | input | BANK_AW | Port A bank number |
| pa_addr | input | WORD_AW | Port A word within bank |
| pa_wdata | input | 36 | Port A write data |
| pa_oe | input | 1 | Port A output enable (asynchronous) |
| pa_pipe | input | 1 | Port A output mode: 1 pipelined, 0 flow-through |
| pa_dout | output | 36 | Port A read data |
| pa_dout_en | output | 1 | Port A bus drive enable |
| pa_coll | output | 1 | Port A bank collision flag |
| pb_cs_n | input | 1 | Port B select, active low |
| pb_cs | input | 1 | Port B select, active high |
| pb_we | input | 1 | Port B: 1 write, 0 read |
| pb_be | input | NBYTES | Port B write lane mask |
| pb_bank | input | BANK_AW | Port B bank number |
| pb_addr | input | WORD_AW | Port B word within bank |
| pb_wdata | input | 36 | Port B write data |
| pb_oe | input | 1 | Port B output enable (asynchronous) |
| pb_pipe | input | 1 | Port B output mode: 1 pipelined, 0 flow-through |
| pb_dout | output | 36 | Port B read data |
| pb_dout_en | output | 1 | Port B bus drive enable |
| pb_coll | output | 1 | Port B bank collision flag |

## Verification
Every request is driven on a falling edge and captured on the next rising edge k. Flow-through read data and collision flags are due after edge k+1, so the bench samples them on the falling edge that follows. Pipelined results are due one edge later and are sampled one falling edge later still. In pipelined mode the bench also checks that the value after edge k+1 is still the old one.

The output enable has no clock. Its effect is checked on the same falling edge on which it is changed, after a short settle delay.

// File: rtl/bsw_pkg.sv
`timescale 1ns/1ps
package bsw_pkg;
  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } out_mode_e;
endpackage

// File: rtl/bsw_port_in.sv
`timescale 1ns/1ps
module bsw_port_in #(
  parameter int BANK_AW = 3,
  parameter int WORD_AW = 6,
  parameter int NBYTES  = 4,
  parameter int DATA_W  = 36
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               cs,
  input  logic               we,
  input  logic [NBYTES-1:0]  be,
  input  logic [BANK_AW-1:0] bank,
  input  logic [WORD_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               act_q,
  output logic               we_q,
  output logic [NBYTES-1:0]  be_q,
  output logic [BANK_AW-1:0] bank_q,
  output logic [WORD_AW-1:0] addr_q,
  output logic [DATA_W-1:0]  wdata_q
);
  logic act_d;

  // port is selected only with both chip selects in their active state
  always_comb act_d = ~cs_n & cs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      we_q  <= we;
    end
  end

  // datapath capture, no reset needed
  always_ff @(posedge clk) begin
    be_q    <= be;
    bank_q  <= bank;
    addr_q  <= addr;
    wdata_q <= wdata;
  end

  a_r5_select_pair: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> $past(!cs_n && cs));
endmodule

// File: rtl/bsw_bank.sv
`timescale 1ns/1ps
module bsw_bank #(
  parameter int WORD_AW = 6,
  parameter int NBYTES  = 4,
  parameter int BYTE_W  = 9,
  localparam int DATA_W = NBYTES * BYTE_W,
  localparam int DEPTH  = 2 ** WORD_AW
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [NBYTES-1:0]  be,
  input  logic [WORD_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar l = 0; l < NBYTES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && be[l]) begin
        mem[addr][l*BYTE_W +: BYTE_W] <= wdata[l*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb rdata = mem[addr];
endmodule

// File: rtl/bsw_port_out.sv
`timescale 1ns/1ps
module bsw_port_out
  import bsw_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  out_mode_e         mode,
  input  logic              oe,
  input  logic              rd_en,
  input  logic              coll,
  input  logic [DATA_W-1:0] bank_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              coll_flag
);
  logic [DATA_W-1:0] ft_q, ft_d, pp_q;
  logic              cf_q, cp_q;

  always_comb begin
    ft_d = ft_q;
    if (rd_en) ft_d = coll ? '0 : bank_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ft_q <= '0;
      pp_q <= '0;
      cf_q <= 1'b0;
      cp_q <= 1'b0;
    end else begin
      ft_q <= ft_d;
      pp_q <= ft_q;
      cf_q <= coll;
      cp_q <= cf_q;
    end
  end

  always_comb begin
    dout_en   = oe;
    dout      = '0;
    if (oe) dout = (mode == OUT_PIPE) ? pp_q : ft_q;
    coll_flag = (mode == OUT_PIPE) ? cp_q : cf_q;
  end

  a_r6_coll_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && coll) |=> (ft_q == '0));
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(ft_q));
  a_r3_pipe_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pp_q == $past(ft_q)));
  a_r7_flag_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cp_q == $past(cf_q)));
endmodule

// File: rtl/bsw_dual_bank_ram.sv
`timescale 1ns/1ps
module bsw_dual_bank_ram
  import bsw_pkg::*;
#(
  parameter int BANK_AW = 3,
  parameter int WORD_AW = 6,
  parameter int NBYTES  = 4,
  parameter int BYTE_W  = 9,
  localparam int DATA_W = NBYTES * BYTE_W,
  localparam int NBANK  = 2 ** BANK_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pa_cs_n,
  input  logic               pa_cs,
  input  logic               pa_we,
  input  logic [NBYTES-1:0]  pa_be,
  input  logic [BANK_AW-1:0] pa_bank,
  input  logic [WORD_AW-1:0] pa_addr,
  input  logic [DATA_W-1:0]  pa_wdata,
  input  logic               pa_oe,
  input  logic               pa_pipe,
  output logic [DATA_W-1:0]  pa_dout,
  output logic               pa_dout_en,
  output logic               pa_coll,
  input  logic               pb_cs_n,
  input  logic               pb_cs,
  input  logic               pb_we,
  input  logic [NBYTES-1:0]  pb_be,
  input  logic [BANK_AW-1:0] pb_bank,
  input  logic [WORD_AW-1:0] pb_addr,
  input  logic [DATA_W-1:0]  pb_wdata,
  input  logic               pb_oe,
  input  logic               pb_pipe,
  output logic [DATA_W-1:0]  pb_dout,
  output logic               pb_dout_en,
  output logic               pb_coll
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  always_comb rst_int_n = rst_sync[1];

  logic               a_act, a_we, b_act, b_we;
  logic [NBYTES-1:0]  a_be, b_be;
  logic [BANK_AW-1:0] a_bank, b_bank;
  logic [WORD_AW-1:0] a_addr, b_addr;
  logic [DATA_W-1:0]  a_wd, b_wd;

  bsw_port_in #(.BANK_AW(BANK_AW), .WORD_AW(WORD_AW), .NBYTES(NBYTES), .DATA_W(DATA_W)) u_in_a (
    .clk(clk), .rst_n(rst_int_n), .cs_n(pa_cs_n), .cs(pa_cs), .we(pa_we), .be(pa_be),
    .bank(pa_bank), .addr(pa_addr), .wdata(pa_wdata),
    .act_q(a_act), .we_q(a_we), .be_q(a_be), .bank_q(a_bank), .addr_q(a_addr), .wdata_q(a_wd));

  bsw_port_in #(.BANK_AW(BANK_AW), .WORD_AW(WORD_AW), .NBYTES(NBYTES), .DATA_W(DATA_W)) u_in_b (
    .clk(clk), .rst_n(rst_int_n), .cs_n(pb_cs_n), .cs(pb_cs), .we(pb_we), .be(pb_be),
    .bank(pb_bank), .addr(pb_addr), .wdata(pb_wdata),
    .act_q(b_act), .we_q(b_we), .be_q(b_be), .bank_q(b_bank), .addr_q(b_addr), .wdata_q(b_wd));

  logic collide;
  always_comb collide = a_act & b_act & (a_bank == b_bank);

  logic [DATA_W-1:0] bank_rd [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic               hit_a, hit_b, wr;
    logic [WORD_AW-1:0] baddr;
    logic [NBYTES-1:0]  bbe;
    logic [DATA_W-1:0]  bwd;

    always_comb begin
      hit_a = a_act & (a_bank == BANK_AW'(g));
      hit_b = b_act & (b_bank == BANK_AW'(g));
      wr    = (hit_a & ~hit_b & a_we) | (hit_b & ~hit_a & b_we);
      baddr = hit_a ? a_addr : b_addr;
      bbe   = hit_a ? a_be   : b_be;
      bwd   = hit_a ? a_wd   : b_wd;
    end

    bsw_bank #(.WORD_AW(WORD_AW), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_bank (
      .clk(clk), .wr_en(wr), .be(bbe), .addr(baddr), .wdata(bwd), .rdata(bank_rd[g]));

    a_r6_no_write_on_clash: assert property (@(posedge clk) disable iff (!rst_int_n)
      (hit_a && hit_b) |-> !wr);
  end

  logic a_rd, b_rd;
  always_comb begin
    a_rd = a_act & ~a_we;
    b_rd = b_act & ~b_we;
  end

  bsw_port_out #(.DATA_W(DATA_W)) u_out_a (
    .clk(clk), .rst_n(rst_int_n), .mode(out_mode_e'(pa_pipe)), .oe(pa_oe),
    .rd_en(a_rd), .coll(collide), .bank_data(bank_rd[a_bank]),
    .dout(pa_dout), .dout_en(pa_dout_en), .coll_flag(pa_coll));

  bsw_port_out #(.DATA_W(DATA_W)) u_out_b (
    .clk(clk), .rst_n(rst_int_n), .mode(out_mode_e'(pb_pipe)), .oe(pb_oe),
    .rd_en(b_rd), .coll(collide), .bank_data(bank_rd[b_bank]),
    .dout(pb_dout), .dout_en(pb_dout_en), .coll_flag(pb_coll));

  a_r7_flow_flag_due: assert property (@(posedge clk) disable iff (!rst_int_n)
    (collide && !pa_pipe && !pb_pipe) |=> (pa_coll && pb_coll));
endmodule

// File: tb/tb_bsw_dual_bank_ram.sv
`timescale 1ns/1ps
module tb_bsw_dual_bank_ram;
  localparam int BA = 3;
  localparam int WA = 6;
  localparam int NB = 4;
  localparam int DW = 36;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic pa_cs_n, pa_cs, pa_we, pa_oe, pa_pipe, pa_dout_en, pa_coll;
  logic pb_cs_n, pb_cs, pb_we, pb_oe, pb_pipe, pb_dout_en, pb_coll;
  logic [NB-1:0] pa_be, pb_be;
  logic [BA-1:0] pa_bank, pb_bank;
  logic [WA-1:0] pa_addr, pb_addr;
  logic [DW-1:0] pa_wdata, pb_wdata, pa_dout, pb_dout;

  bsw_dual_bank_ram dut (
    .clk(clk), .rst_n(rst_n),
    .pa_cs_n(pa_cs_n), .pa_cs(pa_cs), .pa_we(pa_we), .pa_be(pa_be), .pa_bank(pa_bank),
    .pa_addr(pa_addr), .pa_wdata(pa_wdata), .pa_oe(pa_oe), .pa_pipe(pa_pipe),
    .pa_dout(pa_dout), .pa_dout_en(pa_dout_en), .pa_coll(pa_coll),
    .pb_cs_n(pb_cs_n), .pb_cs(pb_cs), .pb_we(pb_we), .pb_be(pb_be), .pb_bank(pb_bank),
    .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_oe(pb_oe), .pb_pipe(pb_pipe),
    .pb_dout(pb_dout), .pb_dout_en(pb_dout_en), .pb_coll(pb_coll));

  localparam logic [DW-1:0] DA  = {9'h1AA, 9'h0BB, 9'h1CC, 9'h0DD};
  localparam logic [DW-1:0] DB  = {9'h0A1, 9'h1B2, 9'h0C3, 9'h1D4};
  localparam logic [DW-1:0] DMW = {9'h111, 9'h122, 9'h133, 9'h144};
  localparam logic [DW-1:0] DM  = {9'h1AA, 9'h122, 9'h1CC, 9'h144};
  localparam logic [DW-1:0] D3  = {9'h155, 9'h066, 9'h177, 9'h088};
  localparam logic [DW-1:0] DX  = {9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF};
  localparam logic [DW-1:0] D7  = {9'h001, 9'h002, 9'h003, 9'h004};
  localparam logic [DW-1:0] D8  = {9'h1F0, 9'h0E1, 9'h1D2, 9'h0C3};
  localparam logic [DW-1:0] Z   = '0;

  typedef struct packed {
    logic a_en; logic a_we; logic [NB-1:0] a_be; logic [BA-1:0] a_bank; logic [WA-1:0] a_addr; logic [DW-1:0] a_wd;
    logic b_en; logic b_we; logic [NB-1:0] b_be; logic [BA-1:0] b_bank; logic [WA-1:0] b_addr; logic [DW-1:0] b_wd;
    logic a_chk; logic [DW-1:0] a_exp; logic b_chk; logic [DW-1:0] b_exp; logic coll;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    // R1 R8: writes to two banks at the same word address
    '{1'b1,1'b1,4'hF,3'd1,6'd5,DA,   1'b1,1'b1,4'hF,3'd2,6'd5,DB,   1'b0,Z, 1'b0,Z, 1'b0},
    // R1 R8: crossed reads
    '{1'b1,1'b0,4'hF,3'd2,6'd5,Z,    1'b1,1'b0,4'hF,3'd1,6'd5,Z,    1'b1,DB,1'b1,DA,1'b0},
    // R4: lane-masked write 0101; B writes bank 3
    '{1'b1,1'b1,4'h5,3'd1,6'd5,DMW,  1'b1,1'b1,4'hF,3'd3,6'd0,D3,   1'b0,Z, 1'b0,Z, 1'b0},
    // R4 R11: merged word read back
    '{1'b1,1'b0,4'hF,3'd1,6'd5,Z,    1'b1,1'b0,4'hF,3'd3,6'd0,Z,    1'b1,DM,1'b1,D3,1'b0},
    // R6 R7: write/read clash in bank 3
    '{1'b1,1'b1,4'hF,3'd3,6'd0,DX,   1'b1,1'b0,4'hF,3'd3,6'd9,Z,    1'b0,Z, 1'b1,Z, 1'b1},
    // R6: clashing write left memory untouched
    '{1'b1,1'b0,4'hF,3'd3,6'd0,Z,    1'b0,1'b0,4'hF,3'd0,6'd0,Z,    1'b1,D3,1'b0,Z, 1'b0},
    // R6 R7: read/read clash in bank 2
    '{1'b1,1'b0,4'hF,3'd2,6'd5,Z,    1'b1,1'b0,4'hF,3'd2,6'd7,Z,    1'b1,Z, 1'b1,Z, 1'b1},
    // R1: edge banks and last word
    '{1'b1,1'b1,4'hF,3'd7,6'd0,D8,   1'b1,1'b1,4'hF,3'd0,6'd63,D7,  1'b0,Z, 1'b0,Z, 1'b0},
    '{1'b1,1'b0,4'hF,3'd0,6'd63,Z,   1'b1,1'b0,4'hF,3'd7,6'd0,Z,    1'b1,D7,1'b1,D8,1'b0},
    '{1'b1,1'b0,4'hF,3'd1,6'd5,Z,    1'b1,1'b0,4'hF,3'd2,6'd5,Z,    1'b1,DM,1'b1,DB,1'b0}
  };

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    pa_cs_n = 1'b1; pa_cs = 1'b0; pa_we = 1'b0; pa_be = '0; pa_bank = '0; pa_addr = '0; pa_wdata = '0;
    pb_cs_n = 1'b1; pb_cs = 1'b0; pb_we = 1'b0; pb_be = '0; pb_bank = '0; pb_addr = '0; pb_wdata = '0;
  endtask

  task automatic set_a(input logic en, input logic we, input logic [NB-1:0] be,
                       input logic [BA-1:0] bk, input logic [WA-1:0] ad, input logic [DW-1:0] wd);
    pa_cs_n = ~en; pa_cs = 1'b1; pa_we = we; pa_be = be; pa_bank = bk; pa_addr = ad; pa_wdata = wd;
  endtask

  task automatic set_b(input logic en, input logic we, input logic [NB-1:0] be,
                       input logic [BA-1:0] bk, input logic [WA-1:0] ad, input logic [DW-1:0] wd);
    pb_cs_n = ~en; pb_cs = 1'b1; pb_we = we; pb_be = be; pb_bank = bk; pb_addr = ad; pb_wdata = wd;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    idle();
    pa_oe = 1'b1; pb_oe = 1'b1; pa_pipe = 1'b0; pb_pipe = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet during reset
    check("R10 a dout in reset", pa_dout, Z);
    check("R10 coll in reset", {34'd0, pa_coll, pb_coll}, Z);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 b dout after reset", pb_dout, Z);
    check("R10 coll after reset", {34'd0, pa_coll, pb_coll}, Z);

    // table walk: issue, capture on edge k, check after edge k+1 (R2)
    for (int i = 0; i < NV; i++) begin
      set_a(VEC[i].a_en, VEC[i].a_we, VEC[i].a_be, VEC[i].a_bank, VEC[i].a_addr, VEC[i].a_wd);
      set_b(VEC[i].b_en, VEC[i].b_we, VEC[i].b_be, VEC[i].b_bank, VEC[i].b_addr, VEC[i].b_wd);
      @(negedge clk);
      idle();
      @(negedge clk);
      if (VEC[i].a_chk) check($sformatf("R2 vec%0d port a data", i), pa_dout, VEC[i].a_exp);
      if (VEC[i].b_chk) check($sformatf("R2 vec%0d port b data", i), pb_dout, VEC[i].b_exp);
      check($sformatf("R7 vec%0d coll a", i), {35'd0, pa_coll}, {35'd0, VEC[i].coll});
      check($sformatf("R7 vec%0d coll b", i), {35'd0, pb_coll}, {35'd0, VEC[i].coll});
      @(negedge clk);
      check($sformatf("R7 vec%0d coll a one cycle", i), {35'd0, pa_coll}, Z);
    end
    // port A last read DM, port B last read DB

    // R5: deselected by each chip select, write must not land, output holds
    set_a(1'b0, 1'b1, 4'hF, 3'd1, 6'd5, DX);
    @(negedge clk); idle(); @(negedge clk);
    check("R5 cs_n high read hold", pa_dout, DM);
    pa_cs_n = 1'b0; pa_cs = 1'b0; pa_we = 1'b1; pa_be = 4'hF; pa_bank = 3'd1; pa_addr = 6'd5; pa_wdata = DX;
    @(negedge clk); idle(); @(negedge clk);
    set_a(1'b1, 1'b0, 4'hF, 3'd1, 6'd5, Z);
    @(negedge clk); idle(); @(negedge clk);
    check("R5 deselected write ignored", pa_dout, DM);

    // R9: output enable off is immediate and keeps the pipeline
    pa_oe = 1'b0; #1;
    check("R9 dout gated", pa_dout, Z);
    check("R9 dout_en low", {35'd0, pa_dout_en}, Z);
    @(negedge clk);
    pa_oe = 1'b1; #1;
    check("R9 data returns", pa_dout, DM);
    check("R9 dout_en high", {35'd0, pa_dout_en}, 36'd1);

    // R3: pipelined mode adds one cycle
    pa_pipe = 1'b1;
    @(negedge clk);
    check("R3 pipe steady", pa_dout, DM);
    set_a(1'b1, 1'b0, 4'hF, 3'd0, 6'd63, Z);
    @(negedge clk); idle(); @(negedge clk);
    check("R3 pipe old value at k+1", pa_dout, DM);
    @(negedge clk);
    check("R3 pipe new value at k+2", pa_dout, D7);

    // R7: pipelined flag one cycle later
    set_a(1'b1, 1'b0, 4'hF, 3'd4, 6'd1, Z);
    set_b(1'b1, 1'b0, 4'hF, 3'd4, 6'd2, Z);
    @(negedge clk); idle(); @(negedge clk);
    check("R7 pipe flag not yet", {35'd0, pa_coll}, Z);
    check("R7 flow flag b", {35'd0, pb_coll}, 36'd1);
    @(negedge clk);
    check("R7 pipe flag due", {35'd0, pa_coll}, 36'd1);
    check("R6 pipe clash data", pa_dout, Z);
    @(negedge clk);
    check("R7 pipe flag clears", {35'd0, pa_coll}, Z);

    // R8 R11: write on B, read on A in other bank, then read-after-write on B
    pa_pipe = 1'b0;
    set_a(1'b1, 1'b0, 4'hF, 3'd7, 6'd0, Z);
    set_b(1'b1, 1'b1, 4'hF, 3'd5, 6'd3, DA);
    @(negedge clk);
    set_a(1'b0, 1'b0, 4'hF, 3'd0, 6'd0, Z);
    set_b(1'b1, 1'b0, 4'hF, 3'd5, 6'd3, Z);
    @(negedge clk);
    idle();
    check("R8 read beside write", pa_dout, D8);
    @(negedge clk);
    check("R11 read after write", pb_dout, DA);

    finish_run();
  end
endmodule